// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sits between the system clock source and the clock gates of the processor and peripheral domains. It produces a gate enable for the processor, memory and internal bus clocks, one gate enable per peripheral, and the enable for the external oscillator. Software sends the block into one of two reduced-power states by writing a small control register. Hardware brings it back to the run state with no software action.

The shallow state is idle. Only the processor-side clocks stop in idle, and peripherals whose enable bit is set keep their clock. Any pending interrupt brings the block back to run, including a synchronised external wake request. The deep state is power-down. Here the oscillator enable drops and every clock is gated. Only a reset or an external wake line that needs no running clock can end this state. That line raises the oscillator enable directly. Once the clock runs again, the request passes through a two-flop synchroniser. Clocks are released only after the oscillator-ready input has been high for a programmable number of consecutive cycles. All register contents are kept through both states.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, cpuClkEn=1, oscEn=1, ctrlBits=2'b00 and periphClkEn equals the parameter PERIPH_RST (all ones by default).
- R2: In run, a ctrlWe pulse with ctrlWdata[0]=1 and ctrlWdata[1]=0 enters idle at that clock edge. After that edge cpuClkEn=0, ctrlBits=2'b01 and periphClkEn equals the peripheral enable register.
- R3: In idle, a non-zero irqPend returns the block to run at the next edge. A synchronised extWakeAsync also returns it to run, three edges after the line rises.
- R4: In run, a ctrlWe pulse with ctrlWdata[1]=1 enters power-down, whatever the value of ctrlWdata[0]. After that edge ctrlBits=2'b10, cpuClkEn=0, periphClkEn=0, and oscEn=0 while extWakeAsync is low.
- R5: In power-down, irqPend has no effect, and all outputs stay in their power-down values.
- R6: In power-down, extWakeAsync drives oscEn high without a clock. After two synchroniser edges and one edge to start settling, the block returns to run on the edge that completes N consecutive cycles with oscReady=1. N is settleLimit clamped to the range 4..4096. A low oscReady restarts the count.
- R7: ctrlBits returns to 2'b00 on the same edge at which the block returns to run.
- R8: In run, a periphWe pulse loads periphWdata into the enable register, and periphClkEn shows it after that edge. The register value comes back unchanged on periphClkEn after idle or power-down.
- R9: ctrlWe and periphWe are ignored in idle, in power-down and while settling.
- R10: An asserted rstN, active low and asynchronous, returns the block to the R1 state from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator output) |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 2 | Bit 0 requests idle, bit 1 requests power-down |
| periphWe | input | 1 | Peripheral enable register write strobe |
| periphWdata | input | NPERIPH | New peripheral enable bits |
| irqPend | input | NIRQ | Enabled interrupt requests, internal sources |
| extWakeAsync | input | 1 | Asynchronous external wake line |
| oscReady | input | 1 | Oscillator stable indication |
| settleLimit | input | LimW | Settle count, clamped to 4..4096 |
| cpuClkEn | output | 1 | Gate enable for processor, memory and bus clocks |
| periphClkEn | output | NPERIPH | Per-peripheral clock gate enables |
| oscEn | output | 1 | Oscillator enable |
| ctrlBits | output | 2 | Control register readback |

## Verification
Some rules are checked on every cycle: the gating that goes with a low oscEn, the fact that power-down never wakes on an internal interrupt, the wake from idle on irqPend, the clearing of the control bits on any wake, oscReady being high just before a release from power-down, and writes having no effect outside run. Other behaviours can only be shown by the bench's scenarios: the exact settle length and how it is clamped at both ends, the restart of the count when oscReady drops, the three-edge latency of the external wake, the priority of power-down over idle, and the peripheral register surviving each state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_IDLE   = 2'd1,
    ST_PDOWN  = 2'd2,
    ST_SETTLE = 2'd3
  } lpmState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptWr;  // register writes allowed
    logic clrCtrl;   // clear control bits (wake done)
    logic cntClr;    // restart settle counter
    logic cntInc;    // advance settle counter
    logic cpuOn;     // processor-side clocks on
    logic periphOn;  // peripheral clocks may follow their enables
    logic oscOn;     // oscillator enabled from the clocked side
    logic pdArm;     // external line may raise the oscillator enable
  } lpmStrobe_t;
endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int NPERIPH = 8,
  parameter logic [NPERIPH-1:0] PERIPH_RST = '1,
  parameter int SETTLE_MIN = 4,
  parameter int SETTLE_MAX = 4096,
  parameter int LimW = $clog2(SETTLE_MAX) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  lpmStrobe_t         strb,
  input  logic               ctrlWe,
  input  logic [1:0]         ctrlWdata,
  input  logic               periphWe,
  input  logic [NPERIPH-1:0] periphWdata,
  input  logic               extWakeAsync,
  input  logic               oscReady,
  input  logic [LimW-1:0]    settleLimit,
  output logic               wrIdle,
  output logic               wrPd,
  output logic               extSync,
  output logic               cntDone,
  output logic               cpuClkEn,
  output logic [NPERIPH-1:0] periphClkEn,
  output logic               oscEn,
  output logic [1:0]         ctrlBits
);
  localparam logic [LimW-1:0] MinL = LimW'(SETTLE_MIN);
  localparam logic [LimW-1:0] MaxL = LimW'(SETTLE_MAX);

  logic [1:0]         ctrlReg;
  logic [NPERIPH-1:0] periphEnReg;
  logic [1:0]         syncFf;
  logic [LimW-1:0]    settleCnt;
  logic [LimW-1:0]    effLimit;

  // decoded, accepted control writes; power-down wins over idle
  assign wrPd   = ctrlWe && strb.acceptWr && ctrlWdata[1];
  assign wrIdle = ctrlWe && strb.acceptWr && ctrlWdata[0] && !ctrlWdata[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= 2'b00;
    end else if (strb.clrCtrl) begin
      ctrlReg <= 2'b00;
    end else if (wrPd) begin
      ctrlReg <= 2'b10;
    end else if (wrIdle) begin
      ctrlReg <= 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periphEnReg <= PERIPH_RST;
    end else if (periphWe && strb.acceptWr) begin
      periphEnReg <= periphWdata;
    end
  end

  // two-flop synchroniser for the external wake line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncFf <= 2'b00;
    end else begin
      syncFf <= {syncFf[0], extWakeAsync};
    end
  end
  assign extSync = syncFf[1];

  // clamp programmed settle length
  always_comb begin
    if (settleLimit < MinL) begin
      effLimit = MinL;
    end else if (settleLimit > MaxL) begin
      effLimit = MaxL;
    end else begin
      effLimit = settleLimit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strb.cntClr) begin
      settleCnt <= '0;
    end else if (strb.cntInc) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  assign cntDone = oscReady && (settleCnt == effLimit - 1'b1);

  assign cpuClkEn    = strb.cpuOn;
  assign periphClkEn = periphEnReg & {NPERIPH{strb.periphOn}};
  // asynchronous path: external line restarts the oscillator with no clock
  assign oscEn       = strb.oscOn || (strb.pdArm && extWakeAsync);
  assign ctrlBits    = ctrlReg;
endmodule

// File: rtl/lpm_control.sv
module lpm_control
  import lpm_pkg::*;
#(
  parameter int NIRQ = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NIRQ-1:0] irqPend,
  input  logic            extSync,
  input  logic            wrIdle,
  input  logic            wrPd,
  input  logic            oscReady,
  input  logic            cntDone,
  output lpmStrobe_t      strb
);
  lpmState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
    end else begin
      state <= stateNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_RUN: begin
        strb.acceptWr = 1'b1;
        strb.cpuOn    = 1'b1;
        strb.periphOn = 1'b1;
        strb.oscOn    = 1'b1;
        if (wrPd) begin
          stateNxt = ST_PDOWN;
        end else if (wrIdle) begin
          stateNxt = ST_IDLE;
        end
      end
      ST_IDLE: begin
        strb.periphOn = 1'b1;
        strb.oscOn    = 1'b1;
        if ((|irqPend) || extSync) begin
          strb.clrCtrl = 1'b1;
          stateNxt     = ST_RUN;
        end
      end
      ST_PDOWN: begin
        // internal interrupts deliberately not examined here
        strb.pdArm  = 1'b1;
        strb.cntClr = 1'b1;
        if (extSync) begin
          stateNxt = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        strb.oscOn = 1'b1;
        if (!oscReady) begin
          strb.cntClr = 1'b1;
        end else if (cntDone) begin
          strb.clrCtrl = 1'b1;
          strb.cntClr  = 1'b1;
          stateNxt     = ST_RUN;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end
endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
  import lpm_pkg::*;
#(
  parameter int NPERIPH = 8,
  parameter int NIRQ = 4,
  parameter logic [NPERIPH-1:0] PERIPH_RST = '1,
  parameter int SETTLE_MIN = 4,
  parameter int SETTLE_MAX = 4096,
  localparam int LimW = $clog2(SETTLE_MAX) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWe,
  input  logic [1:0]         ctrlWdata,
  input  logic               periphWe,
  input  logic [NPERIPH-1:0] periphWdata,
  input  logic [NIRQ-1:0]    irqPend,
  input  logic               extWakeAsync,
  input  logic               oscReady,
  input  logic [LimW-1:0]    settleLimit,
  output logic               cpuClkEn,
  output logic [NPERIPH-1:0] periphClkEn,
  output logic               oscEn,
  output logic [1:0]         ctrlBits
);
  lpmStrobe_t strb;
  logic wrIdle, wrPd, extSync, cntDone;

  lpm_control #(.NIRQ(NIRQ)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irqPend  (irqPend),
    .extSync  (extSync),
    .wrIdle   (wrIdle),
    .wrPd     (wrPd),
    .oscReady (oscReady),
    .cntDone  (cntDone),
    .strb     (strb)
  );

  lpm_datapath #(
    .NPERIPH    (NPERIPH),
    .PERIPH_RST (PERIPH_RST),
    .SETTLE_MIN (SETTLE_MIN),
    .SETTLE_MAX (SETTLE_MAX),
    .LimW       (LimW)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .ctrlWe       (ctrlWe),
    .ctrlWdata    (ctrlWdata),
    .periphWe     (periphWe),
    .periphWdata  (periphWdata),
    .extWakeAsync (extWakeAsync),
    .oscReady     (oscReady),
    .settleLimit  (settleLimit),
    .wrIdle       (wrIdle),
    .wrPd         (wrPd),
    .extSync      (extSync),
    .cntDone      (cntDone),
    .cpuClkEn     (cpuClkEn),
    .periphClkEn  (periphClkEn),
    .oscEn        (oscEn),
    .ctrlBits     (ctrlBits)
  );
endmodule

// File: rtl/lpm_clock_ctrl_chk.sv
module lpm_clock_ctrl_chk #(
  parameter int NPERIPH = 8,
  parameter int NIRQ = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuClkEn,
  input logic [NPERIPH-1:0] periphClkEn,
  input logic               oscEn,
  input logic [1:0]         ctrlBits,
  input logic [NIRQ-1:0]    irqPend,
  input logic               oscReady
);
  // R4
  pd_gates_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!cpuClkEn && periphClkEn == '0));

  // R5
  pd_ignores_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |=> !cpuClkEn);

  // R3
  idle_irq_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && ctrlBits == 2'b01 && (|irqPend)) |=> cpuClkEn);

  // R2
  idle_keeps_periph_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && ctrlBits == 2'b01) |=> $stable(periphClkEn));

  // R7
  wake_clears_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClkEn) |-> ctrlBits == 2'b00);

  // R6
  settle_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cpuClkEn) && $past(ctrlBits) == 2'b10) |-> $past(oscReady));

  // R9
  no_write_asleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuClkEn |=> (ctrlBits == $past(ctrlBits) || ctrlBits == 2'b00));
endmodule

bind lpm_clock_ctrl lpm_clock_ctrl_chk #(.NPERIPH(NPERIPH), .NIRQ(NIRQ)) u_chk (.*);

// File: tb/lpm_clock_ctrl_bench.sv
module lpm_clock_ctrl_bench;
  localparam int NP = 8;
  localparam int NI = 4;
  localparam int LW = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0;
  logic [1:0] ctrlWdata = '0;
  logic periphWe = 1'b0;
  logic [NP-1:0] periphWdata = '0;
  logic [NI-1:0] irqPend = '0;
  logic extWakeAsync = 1'b0;
  logic oscReady = 1'b0;
  logic [LW-1:0] settleLimit = 13'd4;
  logic cpuClkEn, oscEn;
  logic [NP-1:0] periphClkEn;
  logic [1:0] ctrlBits;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [NP-1:0] modelPeriph;
  int unsigned seed;

  always #4 clk = ~clk;

  lpm_clock_ctrl u_lpm_clock_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .periphWe(periphWe), .periphWdata(periphWdata), .irqPend(irqPend),
    .extWakeAsync(extWakeAsync), .oscReady(oscReady), .settleLimit(settleLimit),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .oscEn(oscEn), .ctrlBits(ctrlBits)
  );

  function automatic int effSettle(int v);
    if (v < 4) return 4;
    if (v > 4096) return 4096;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance n rising edges, return just after the following falling edge
  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic writeCtrl(logic [1:0] v);
    ctrlWe = 1'b1; ctrlWdata = v;
    step(1);
    ctrlWe = 1'b0; ctrlWdata = '0;
  endtask

  task automatic writePeriph(logic [NP-1:0] v);
    periphWe = 1'b1; periphWdata = v;
    step(1);
    periphWe = 1'b0;
  endtask

  task automatic checkRun(string req);
    chk(req, {31'd0, cpuClkEn}, 32'd1);
    chk(req, {30'd0, ctrlBits}, 32'd0);
    chk(req, {24'd0, periphClkEn}, {24'd0, modelPeriph});
  endtask

  // power-down entry then external wake with a given settle value
  task automatic pdCycle(int lim, bit withDrop);
    int eff;
    eff = effSettle(lim);
    settleLimit = LW'(lim);
    writeCtrl(2'b11);
    chk("R4", {30'd0, ctrlBits}, 32'd2);
    chk("R4", {oscEn, cpuClkEn, 22'd0, periphClkEn}, 32'd0);
    // internal interrupts and writes during power-down
    for (int i = 0; i < 4; i++) begin
      irqPend = NI'($urandom_range(1, 15));
      ctrlWe = 1'b1; ctrlWdata = 2'b01;
      periphWe = 1'b1; periphWdata = NP'($urandom);
      step(1);
      chk("R5", {oscEn, cpuClkEn, 22'd0, periphClkEn}, 32'd0);
      chk("R9", {30'd0, ctrlBits}, 32'd2);
    end
    irqPend = '0; ctrlWe = 1'b0; periphWe = 1'b0; ctrlWdata = '0;
    oscReady = 1'b1;
    extWakeAsync = 1'b1;
    #1;
    chk("R6 async osc", {31'd0, oscEn}, 32'd1);
    if (withDrop) begin
      step(5);          // edges 1..5: sync, settle entry, two ready cycles
      oscReady = 1'b0;
      step(1);          // edge 6 restarts the count
      oscReady = 1'b1;
      step(eff - 1);
      chk("R6 restart", {31'd0, cpuClkEn}, 32'd0);
      step(1);
    end else begin
      step(2 + eff);
      chk("R6 settle", {31'd0, cpuClkEn}, 32'd0);
      step(1);
    end
    chk("R6 release", {31'd0, cpuClkEn}, 32'd1);
    chk("R7", {30'd0, ctrlBits}, 32'd0);
    chk("R8 held", {24'd0, periphClkEn}, {24'd0, modelPeriph});
    extWakeAsync = 1'b0;
    step(3);
  endtask

  initial begin
    seed = 32'd1234;
    void'($urandom(seed));
    modelPeriph = '1;
    #1;
    chk("R1 in reset", {31'd0, cpuClkEn}, 32'd1);
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1", {31'd0, oscEn}, 32'd1);
    checkRun("R1");

    // random peripheral writes and idle rounds
    for (int r = 0; r < 12; r++) begin
      logic [NP-1:0] v;
      int w;
      v = NP'($urandom);
      writePeriph(v);
      modelPeriph = v;
      chk("R8", {24'd0, periphClkEn}, {24'd0, modelPeriph});
      writeCtrl(2'b01);
      chk("R2", {31'd0, cpuClkEn}, 32'd0);
      chk("R2", {30'd0, ctrlBits}, 32'd1);
      chk("R2", {24'd0, periphClkEn}, {24'd0, modelPeriph});
      w = $urandom_range(0, 6);
      for (int k = 0; k < w; k++) begin
        periphWe = 1'b1; periphWdata = ~modelPeriph;
        step(1);
        chk("R9 idle", {24'd0, cpuClkEn, periphClkEn}, {24'd0, 1'b0, modelPeriph});
      end
      periphWe = 1'b0;
      if (r % 4 == 3) begin
        extWakeAsync = 1'b1;
        step(2);
        chk("R3 ext sync", {31'd0, cpuClkEn}, 32'd0);
        step(1);
        extWakeAsync = 1'b0;
        checkRun("R3 ext");
        step(2);
      end else begin
        irqPend = NI'(1 << $urandom_range(0, NI - 1));
        step(1);
        irqPend = '0;
        checkRun("R3 irq");
      end
    end

    // power-down with directed and random settle lengths
    pdCycle(0, 1'b0);      // clamps up to 4
    pdCycle(4, 1'b0);
    pdCycle(5000, 1'b0);   // clamps down to 4096
    pdCycle(4096, 1'b0);
    pdCycle(9, 1'b1);
    for (int r = 0; r < 6; r++) begin
      pdCycle($urandom_range(4, 60), r[0]);
    end

    // reset from power-down
    writePeriph(8'h3c);
    modelPeriph = 8'h3c;
    writeCtrl(2'b10);
    chk("R4 pd only", {30'd0, ctrlBits}, 32'd2);
    rstN = 1'b0;
    #1;
    chk("R10", {31'd0, cpuClkEn}, 32'd1);
    step(2);
    rstN = 1'b1;
    step(1);
    modelPeriph = '1;
    checkRun("R10");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule